// File: doc/BRIEF.md
# Shared Frame Check Sequence Engine with Loopback Steering

This block holds one CRC-32 frame check sequence engine and steers it between the transmit and receive byte streams of a MAC. It is never used by both directions at once. On the transmit side the engine lets outgoing frames carry four appended check bytes. On the receive side it checks the trailing check bytes of incoming frames. The same engine also produces the 6-bit hash that indexes a 64-bit group address filter.

In loopback, one configuration bit fixes which direction owns the engine. With the bit at 0 the transmitter appends the check field and the receiver reports frames as unchecked. With the bit at 1 the transmitter sends the buffer as given, with software supplying the last four bytes, and the receiver verifies them and applies the group filter. Outside loopback the engine is taken by whichever direction starts a frame first. Transmit wins when both start in the same cycle. A frame that starts while the other direction holds the engine goes through unserved. A registered collision-enable output is dropped while external loopback runs on the twisted-pair port.

Top module: `fcs_share_unit`

## Requirements
- R1: After reset, tx_in_ready=1, tx_out_valid=0, eng_owner=2'b00, coll_en=1, and rx_done, rx_chk, rx_fcs_err and rx_mc_hit are 0.
- R2: eng_owner shows the engine holder (2'b00 free, 2'b01 transmit, 2'b10 receive) and never has both bits set.
- R3: A served transmit frame of N bytes leaves as N+4 consecutive valid bytes. The added bytes are the complement of the right-shifting CRC register (reflected polynomial 0xEDB88320, register preset to all ones, data bit 0 first), sent least significant byte first. tx_in_ready is low for the 4 cycles after the last input byte is accepted, with tx_out_last on the final added byte.
- R4: In loopback with rx_alloc=0, receive frames are reported with rx_chk=0, rx_fcs_err=0 and rx_mc_hit=0.
- R5: In loopback with rx_alloc=1, transmit frames pass through unchanged in length and content, and tx_in_ready stays high.
- R6: For a served receive frame, rx_chk=1. rx_fcs_err=1 exactly when the register after the final byte differs from 0xDEBB20E3, the reflected form of residue 0xC704DD7B.
- R7: For a served receive frame, rx_mc_hit=1 exactly when the frame has at least 6 bytes, bit 0 of its first byte is 1, and filter bit mc_filter[idx] is 1. Here idx = {r[0],r[1],r[2],r[3],r[4],r[5]} of the register r after the first 6 bytes, with r[0] as the most significant index bit.
- R8: Outside loopback, the first direction to start a frame while the engine is free takes it. Transmit wins a same-cycle start. A frame of the other direction that starts during that ownership is unserved: a transmit frame gets no check bytes, and a receive frame reports rx_chk=0.
- R9: coll_en is 0 from the clock edge after lpbk_en, ext_lpbk and tp_sel are all 1, and 1 from the edge after any of them is 0.
- R10: tx_out carries an accepted input byte one cycle after acceptance. rx_done pulses for one cycle, the cycle after the byte with rx_last is taken, and carries that frame's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lpbk_en | input | 1 | Loopback mode active |
| ext_lpbk | input | 1 | Loopback is external rather than internal |
| tp_sel | input | 1 | Twisted-pair port selected |
| rx_alloc | input | 1 | Loopback engine allocation: 0 transmit, 1 receive |
| mc_filter | input | 64 | Group address filter bits |
| tx_in_valid | input | 1 | Transmit input byte valid |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_last | input | 1 | Last byte of transmit buffer |
| tx_in_ready | output | 1 | Transmit input accepted this cycle when valid |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_data | output | 8 | Transmit output byte |
| tx_out_last | output | 1 | Last byte of outgoing frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of receive frame |
| rx_done | output | 1 | Receive status valid pulse |
| rx_chk | output | 1 | Frame was served by the engine |
| rx_fcs_err | output | 1 | Check sequence mismatch |
| rx_mc_hit | output | 1 | Group address passed the filter |
| eng_owner | output | 2 | Current engine holder |
| coll_en | output | 1 | Collision detection enable |

## Verification
The hardest case to reach is two directions contending for the engine outside loopback. One variant has both streams starting in the very same cycle. In the other, a transmit frame begins while a receive frame already holds the engine. The bench starts both drivers in one fork so that their first bytes land on the same clock edge. For the second variant it delays the transmit driver by two cycles behind an active receive frame. It then reads eng_owner, the length of the transmit output and rx_chk to see which side was served.

// File: rtl/fcs_share_pkg.sv
package fcs_share_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'b00,
      OWN_TX   = 2'b01,
      OWN_RX   = 2'b10
   } own_e;
endpackage

// File: rtl/fcs_crc_core.sv
module fcs_crc_core #(
   parameter int              DATA_W = 8,
   parameter int              CRC_W  = 32,
   parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc_q,
   output logic [CRC_W-1:0]  crc_nx
);
   logic [CRC_W-1:0] stage [0:DATA_W];

   assign stage[0] = restart ? '1 : crc_q;

   // one shift stage per data bit, bit 0 first
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign stage[b+1] = (stage[b][0] ^ din[b]) ? ((stage[b] >> 1) ^ POLY)
                                                    : (stage[b] >> 1);
      end
   endgenerate

   assign crc_nx = stage[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= '1;
      else if (step) crc_q <= crc_nx;
   end
endmodule

// File: rtl/fcs_tx_path.sv
module fcs_tx_path #(
   parameter int DATA_W    = 8,
   parameter int CRC_W     = 32,
   parameter int FCS_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   input  logic              grant,
   input  logic              owned,
   input  logic [CRC_W-1:0]  crc_q,
   output logic              sof,
   output logic              step,
   output logic              release_eng,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);
   localparam int               CNT_W    = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
   localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_BYTES - 1);

   logic             first_q;
   logic             in_fcs;
   logic [CNT_W-1:0] fcs_idx;
   logic             accept;
   logic             serving;
   logic [DATA_W-1:0] fcs_byte;

   assign in_ready    = !in_fcs;
   assign accept      = in_valid && in_ready;
   assign sof         = accept && first_q;
   assign serving     = sof ? grant : owned;
   assign step        = accept && serving;
   assign release_eng = in_fcs && (fcs_idx == FCS_LAST);
   assign fcs_byte    = ~crc_q[fcs_idx*DATA_W +: DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q   <= 1'b1;
         in_fcs    <= 1'b0;
         fcs_idx   <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (in_fcs) begin
         out_valid <= 1'b1;
         out_data  <= fcs_byte;
         out_last  <= (fcs_idx == FCS_LAST);
         if (fcs_idx == FCS_LAST) begin
            in_fcs  <= 1'b0;
            fcs_idx <= '0;
         end else begin
            fcs_idx <= fcs_idx + 1'b1;
         end
      end else if (accept) begin
         out_valid <= 1'b1;
         out_data  <= in_data;
         first_q   <= in_last;
         if (in_last && serving) begin
            in_fcs   <= 1'b1;
            out_last <= 1'b0;
         end else begin
            out_last <= in_last;
         end
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end
   end
endmodule

// File: rtl/fcs_rx_path.sv
module fcs_rx_path #(
   parameter int               DATA_W   = 8,
   parameter int               CRC_W    = 32,
   parameter logic [CRC_W-1:0] RESIDUE  = 32'hDEBB20E3,
   parameter int               DA_BYTES = 6,
   parameter int               HASH_W   = 6,
   parameter int               FILT_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic              grant,
   input  logic              owned,
   input  logic [CRC_W-1:0]  crc_nx,
   input  logic [FILT_W-1:0] filter,
   output logic              sof,
   output logic              step,
   output logic              release_eng,
   output logic              done,
   output logic              chk,
   output logic              fcs_err,
   output logic              mc_hit
);
   localparam int              CW      = $clog2(DA_BYTES + 1);
   localparam logic [CW-1:0]   DA_LAST = CW'(DA_BYTES - 1);
   localparam logic [CW-1:0]   DA_FULL = CW'(DA_BYTES);

   logic              first_q;
   logic [CW-1:0]     cnt;
   logic              grp_q;
   logic              hit_q;
   logic              serving;
   logic              cur_grp;
   logic              da_end;
   logic              new_hit;
   logic [HASH_W-1:0] hash_idx;

   // index MSB taken from register bit 0
   generate
      for (genvar h = 0; h < HASH_W; h++) begin : g_hash
         assign hash_idx[HASH_W-1-h] = crc_nx[h];
      end
   endgenerate

   assign sof         = in_valid && first_q;
   assign serving     = sof ? grant : owned;
   assign step        = in_valid && serving;
   assign release_eng = in_valid && in_last && serving;
   assign cur_grp     = sof ? in_data[0] : grp_q;
   assign da_end      = in_valid && (cnt == DA_LAST);
   assign new_hit     = serving && cur_grp && filter[hash_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         cnt     <= '0;
         grp_q   <= 1'b0;
         hit_q   <= 1'b0;
         done    <= 1'b0;
         chk     <= 1'b0;
         fcs_err <= 1'b0;
         mc_hit  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (in_valid) begin
            first_q <= in_last;
            if (sof) grp_q <= in_data[0];
            if (in_last)            cnt <= '0;
            else if (cnt != DA_FULL) cnt <= cnt + 1'b1;
            if (da_end) hit_q <= new_hit;
            if (in_last) begin
               done    <= 1'b1;
               chk     <= serving;
               fcs_err <= serving && (crc_nx != RESIDUE);
               mc_hit  <= da_end ? new_hit : ((cnt == DA_FULL) && hit_q);
            end
         end
      end
   end
endmodule

// File: rtl/fcs_share_unit.sv
module fcs_share_unit
   import fcs_share_pkg::*;
#(
   parameter int               DATA_W    = 8,
   parameter int               CRC_W     = 32,
   parameter logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320,
   parameter logic [CRC_W-1:0] RESIDUE   = 32'hDEBB20E3,
   parameter int               HASH_W    = 6,
   parameter int               DA_BYTES  = 6,
   localparam int              FILT_W    = 1 << HASH_W,
   localparam int              FCS_BYTES = CRC_W / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lpbk_en,
   input  logic              ext_lpbk,
   input  logic              tp_sel,
   input  logic              rx_alloc,
   input  logic [FILT_W-1:0] mc_filter,
   input  logic              tx_in_valid,
   input  logic [DATA_W-1:0] tx_in_data,
   input  logic              tx_in_last,
   output logic              tx_in_ready,
   output logic              tx_out_valid,
   output logic [DATA_W-1:0] tx_out_data,
   output logic              tx_out_last,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_last,
   output logic              rx_done,
   output logic              rx_chk,
   output logic              rx_fcs_err,
   output logic              rx_mc_hit,
   output logic [1:0]        eng_owner,
   output logic              coll_en
);
   generate
      if (DATA_W < 1 || CRC_W % DATA_W != 0) begin : g_bad_width
         $error("CRC_W must be a whole number of DATA_W bytes");
      end
      if (HASH_W < 1 || HASH_W > CRC_W || HASH_W > 12) begin : g_bad_hash
         $error("HASH_W out of range");
      end
      if (DA_BYTES < 1) begin : g_bad_da
         $error("DA_BYTES must be at least 1");
      end
   endgenerate

   own_e              owner_q;
   logic              eng_free;
   logic              tx_grant, rx_grant;
   logic              tx_sof, tx_step, tx_rel;
   logic              rx_sof, rx_step, rx_rel;
   logic              crc_restart, crc_step;
   logic [DATA_W-1:0] crc_din;
   logic [CRC_W-1:0]  crc_q, crc_nx;

   assign eng_free = (owner_q == OWN_IDLE);
   assign tx_grant = eng_free && (lpbk_en ? !rx_alloc : 1'b1);
   assign rx_grant = eng_free && (lpbk_en ? rx_alloc : !tx_sof);

   assign crc_restart = (tx_sof && tx_grant) || (rx_sof && rx_grant);
   assign crc_step    = tx_step || rx_step;
   assign crc_din     = tx_step ? tx_in_data : rx_data;
   assign eng_owner   = owner_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_IDLE;
      end else begin
         unique case (owner_q)
            OWN_IDLE: begin
               if (tx_sof && tx_grant)                 owner_q <= OWN_TX;
               else if (rx_sof && rx_grant && !rx_rel) owner_q <= OWN_RX;
            end
            OWN_TX:   if (tx_rel) owner_q <= OWN_IDLE;
            OWN_RX:   if (rx_rel) owner_q <= OWN_IDLE;
            default:  owner_q <= OWN_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coll_en <= 1'b1;
      else        coll_en <= !(lpbk_en && ext_lpbk && tp_sel);
   end

   fcs_crc_core #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY_REFL)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (crc_restart),
      .step    (crc_step),
      .din     (crc_din),
      .crc_q   (crc_q),
      .crc_nx  (crc_nx)
   );

   fcs_tx_path #(.DATA_W(DATA_W), .CRC_W(CRC_W), .FCS_BYTES(FCS_BYTES)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (tx_in_valid),
      .in_data     (tx_in_data),
      .in_last     (tx_in_last),
      .in_ready    (tx_in_ready),
      .grant       (tx_grant),
      .owned       (owner_q == OWN_TX),
      .crc_q       (crc_q),
      .sof         (tx_sof),
      .step        (tx_step),
      .release_eng (tx_rel),
      .out_valid   (tx_out_valid),
      .out_data    (tx_out_data),
      .out_last    (tx_out_last)
   );

   fcs_rx_path #(.DATA_W(DATA_W), .CRC_W(CRC_W), .RESIDUE(RESIDUE),
                 .DA_BYTES(DA_BYTES), .HASH_W(HASH_W), .FILT_W(FILT_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (rx_valid),
      .in_data     (rx_data),
      .in_last     (rx_last),
      .grant       (rx_grant),
      .owned       (owner_q == OWN_RX),
      .crc_nx      (crc_nx),
      .filter      (mc_filter),
      .sof         (rx_sof),
      .step        (rx_step),
      .release_eng (rx_rel),
      .done        (rx_done),
      .chk         (rx_chk),
      .fcs_err     (rx_fcs_err),
      .mc_hit      (rx_mc_hit)
   );
endmodule

// File: rtl/fcs_share_chk.sv
module fcs_share_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        lpbk_en,
   input logic        ext_lpbk,
   input logic        tp_sel,
   input logic        rx_alloc,
   input logic [63:0] mc_filter,
   input logic        tx_in_valid,
   input logic [7:0]  tx_in_data,
   input logic        tx_in_last,
   input logic        tx_in_ready,
   input logic        tx_out_valid,
   input logic [7:0]  tx_out_data,
   input logic        tx_out_last,
   input logic        rx_valid,
   input logic [7:0]  rx_data,
   input logic        rx_last,
   input logic        rx_done,
   input logic        rx_chk,
   input logic        rx_fcs_err,
   input logic        rx_mc_hit,
   input logic [1:0]  eng_owner,
   input logic        coll_en
);
   p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eng_owner));

   p_fcs_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_in_ready) |=> !tx_in_ready);

   p_unchecked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && !rx_chk |-> !rx_fcs_err && !rx_mc_hit);

   p_rx_alloc0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && lpbk_en && !rx_alloc && $past(lpbk_en && !rx_alloc) |-> !rx_chk);

   p_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lpbk_en && rx_alloc && $past(lpbk_en && rx_alloc && tx_in_ready) |-> tx_in_ready);

   p_coll_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lpbk_en && ext_lpbk && tp_sel |=> !coll_en);

   p_tx_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_in_valid && tx_in_ready |=> tx_out_valid);

   p_rx_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_last |=> rx_done);
endmodule

bind fcs_share_unit fcs_share_chk u_chk (.*);

// File: tb/fcs_share_unit_test.sv
`timescale 1ns/1ps
module fcs_share_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lpbk_en = 1'b0, ext_lpbk = 1'b0, tp_sel = 1'b0, rx_alloc = 1'b0;
   logic [63:0] mc_filter = '0;
   logic        tx_in_valid = 1'b0, tx_in_last = 1'b0;
   logic [7:0]  tx_in_data = '0;
   logic        tx_in_ready, tx_out_valid, tx_out_last;
   logic [7:0]  tx_out_data;
   logic        rx_valid = 1'b0, rx_last = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_done, rx_chk, rx_fcs_err, rx_mc_hit, coll_en;
   logic [1:0]  eng_owner;

   always #2 clk = ~clk;

   fcs_share_unit uut (.*);

   // vector: {lpbk, alloc, corrupt, group, fsel[1:0], len[7:0], seed[7:0]}
   localparam int NV = 10;
   localparam logic [21:0] VEC [0:NV-1] = '{
      {1'b0,1'b0,1'b0,1'b1,2'd1,8'd20,8'd11},
      {1'b1,1'b0,1'b0,1'b1,2'd1,8'd12,8'd33},
      {1'b1,1'b1,1'b0,1'b1,2'd1,8'd16,8'd55},
      {1'b1,1'b1,1'b1,1'b0,2'd1,8'd10,8'd77},
      {1'b0,1'b0,1'b0,1'b1,2'd0,8'd6, 8'd99},
      {1'b0,1'b0,1'b0,1'b1,2'd1,8'd3, 8'd121},
      {1'b1,1'b1,1'b0,1'b1,2'd2,8'd1, 8'd143},
      {1'b0,1'b0,1'b0,1'b1,2'd2,8'd64,8'd200},
      {1'b1,1'b0,1'b0,1'b0,2'd2,8'd1, 8'd17},
      {1'b0,1'b0,1'b1,1'b1,2'd2,8'd8, 8'd5}
   };
   localparam logic [63:0] PATTERN = 64'h5A3C_96F0_0FE1_7B24;

   int   n_chk = 0, n_bad = 0;
   logic [7:0] txbuf [0:299];
   logic [7:0] rxbuf [0:299];
   logic [7:0] cap   [0:299];
   int   cap_n = 0;
   bit   cap_done = 0, rx_seen = 0, finished = 0;
   logic got_chk, got_err, got_hit;

   function automatic logic [31:0] crc_run(input logic [31:0] r, input logic [7:0] b);
      logic [31:0] c = r;
      for (int k = 0; k < 8; k++) begin
         if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
         else             c = c >> 1;
      end
      return c;
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic send_tx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!tx_in_ready) @(negedge clk);
         tx_in_valid = 1'b1; tx_in_data = txbuf[i]; tx_in_last = (i == n-1);
      end
      @(negedge clk);
      tx_in_valid = 1'b0; tx_in_last = 1'b0;
   endtask

   task automatic send_rx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = rxbuf[i]; rx_last = (i == n-1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   always @(negedge clk) begin
      if (tx_out_valid) begin
         cap[cap_n] = tx_out_data;
         cap_n = cap_n + 1;
         if (tx_out_last) cap_done = 1;
      end
      if (rx_done) begin
         rx_seen = 1; got_chk = rx_chk; got_err = rx_fcs_err; got_hit = rx_mc_hit;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ready", tx_in_ready, 1);
      check("R1 out_valid", tx_out_valid, 0);
      check("R1 owner", eng_owner, 0);
      check("R1 coll_en", coll_en, 1);
      check("R1 rx status", {rx_done, rx_chk, rx_fcs_err, rx_mc_hit}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         logic lp, al, cor, grp;
         logic [1:0] fs;
         int len, n, exp_n;
         logic [31:0] c;
         logic srv_tx, srv_rx, bad, exp_err, exp_hit;
         {lp, al, cor, grp, fs} = VEC[v][21:16];
         len = int'(VEC[v][15:8]);
         for (int i = 0; i < len; i++)
            txbuf[i] = 8'(int'(VEC[v][7:0]) + i*29 + (i >> 2));
         txbuf[0][0] = grp;
         n = len;
         if (lp && al) begin
            c = 32'hFFFFFFFF;
            for (int i = 0; i < len; i++) c = crc_run(c, txbuf[i]);
            for (int k = 0; k < 4; k++) txbuf[len+k] = ~c[8*k +: 8];
            n = len + 4;
         end
         lpbk_en = lp; rx_alloc = al;
         mc_filter = (fs == 2'd0) ? 64'h0 : (fs == 2'd1) ? ~64'h0 : PATTERN;
         repeat (2) @(negedge clk);
         srv_tx = lp ? !al : 1'b1;
         srv_rx = lp ? al : 1'b1;
         cap_n = 0; cap_done = 0;
         send_tx(n);
         while (!cap_done) @(negedge clk);
         exp_n = n + (srv_tx ? 4 : 0);
         check(srv_tx ? "R3 length" : "R5 length", cap_n, exp_n);
         bad = 0;
         for (int i = 0; i < n; i++) if (cap[i] !== txbuf[i]) bad = 1;
         if (srv_tx) begin
            c = 32'hFFFFFFFF;
            for (int i = 0; i < n; i++) c = crc_run(c, txbuf[i]);
            for (int k = 0; k < 4; k++) if (cap[n+k] !== ~c[8*k +: 8]) bad = 1;
         end
         check(srv_tx ? "R3 content" : "R5 content", bad, 0);
         // loop captured frame back into the receiver
         for (int i = 0; i < cap_n; i++) rxbuf[i] = cap[i];
         if (cor) rxbuf[0][1] = ~rxbuf[0][1];
         c = 32'hFFFFFFFF;
         for (int i = 0; i < cap_n; i++) c = crc_run(c, rxbuf[i]);
         exp_err = srv_rx && (c != 32'hDEBB20E3);
         c = 32'hFFFFFFFF;
         for (int i = 0; i < 6 && i < cap_n; i++) c = crc_run(c, rxbuf[i]);
         exp_hit = srv_rx && rxbuf[0][0] && (cap_n >= 6) &&
                   mc_filter[{c[0], c[1], c[2], c[3], c[4], c[5]}];
         rx_seen = 0;
         send_rx(cap_n);
         while (!rx_seen) @(negedge clk);
         check(srv_rx ? "R6 rx_chk" : "R4 rx_chk", got_chk, srv_rx);
         check(srv_rx ? "R6 fcs_err" : "R4 fcs_err", got_err, exp_err);
         check(srv_rx ? "R7 mc_hit" : "R4 mc_hit", got_hit, exp_hit);
         repeat (2) @(negedge clk);
      end

      // R9 collision enable
      lpbk_en = 1; ext_lpbk = 1; tp_sel = 1;
      @(negedge clk);
      check("R9 coll off", coll_en, 0);
      tp_sel = 0;
      @(negedge clk);
      check("R9 coll on aui", coll_en, 1);
      ext_lpbk = 0; tp_sel = 1;
      @(negedge clk);
      check("R9 coll on internal", coll_en, 1);
      lpbk_en = 0; ext_lpbk = 0; tp_sel = 0;
      mc_filter = ~64'h0;
      repeat (2) @(negedge clk);

      // R8 same-cycle start: transmit wins
      for (int i = 0; i < 10; i++) begin txbuf[i] = 8'(i*7 + 3); rxbuf[i] = 8'(i*13 + 1); end
      cap_n = 0; cap_done = 0; rx_seen = 0;
      fork
         send_tx(10);
         send_rx(10);
         begin
            @(negedge clk); @(negedge clk);
            check("R8 tx priority owner", eng_owner, 2'b01);
         end
      join
      while (!cap_done || !rx_seen) @(negedge clk);
      check("R8 tx appended", cap_n, 14);
      check("R8 rx unserved", got_chk, 0);
      repeat (2) @(negedge clk);

      // R8 receive holds engine, transmit arriving later is unserved
      cap_n = 0; cap_done = 0; rx_seen = 0;
      fork
         send_rx(10);
         begin
            @(negedge clk); @(negedge clk);
            check("R8 rx owner", eng_owner, 2'b10);
            send_tx(5);
         end
      join
      while (!cap_done || !rx_seen) @(negedge clk);
      check("R8 tx not appended", cap_n, 5);
      check("R8 rx served", got_chk, 1);
      repeat (6) @(negedge clk);
      check("R2 owner released", eng_owner, 2'b00);

      // R10 rx_done is a single-cycle pulse
      check("R10 done cleared", rx_done, 0);
      finish_run();
   end
endmodule